// File: doc/BRIEF.md
# Instruction Format Decoder with Register File

This block turns one 32-bit instruction word of a small load/store RISC subset into the control and operand values that a datapath needs to run it. The two most significant bits pick one of four format classes: control transfer with link, arithmetic/logic/shift, memory access, and a shared class holding conditional branches and the upper-immediate load. From the rest of the word it takes the register fields, the operation code, the immediate-select bit and the immediate or displacement fields. It drives an ALU operation code, condition-code update, memory read and write strobes, a next-PC source select and a byte displacement.

A register file with one write port and three read ports sits behind the decoder. The ports carry the first source, the second source and the store-data register. Register 0 always reads as zero. The second operand is already muxed between the register value and the expanded immediate. The write data is the datapath result given on `wr_data_i`, except for the upper-immediate load, whose value the block builds and writes itself. The condition flags come in from outside and decide whether a branch is taken.

Top module: `instr_decode_unit`

## Requirements
- R1: When bits 31:30 are 01 (call), the block sets `rf_we_o`=1, sets `rf_waddr_o`=15 and sets `pc_sel_o`=1 (relative). `pc_disp_o` is bits 29:0 shifted left by two.
- R2: When bits 31:30 are 10, op3 (bits 24:19) selects `alu_op_o`: 010000 gives add (0), 010001 and (1), 010010 or (2), 010110 or-not (3), 100110 shift right logical (4) and 010100 subtract (5). Each of these writes register rd (bits 29:25). `set_cc_o` is 1 for all of them except the shift.
- R3: When bit 13 is 0, `src_b_o` is register rs2 (bits 4:0). When bit 13 is 1, `src_b_o` is bits 12:0 expanded to 32 bits: sign-extended for add, subtract, jump-and-link, load and store; zero-extended for and, or and or-not; only bits 4:0, zero-extended, for the shift. `src_a_o` is register rs1 (bits 18:14).
- R4: When bits 31:30 are 11, op3 000000 is a load: `mem_rd_o`=1 and rd is written. Op3 000100 is a store: `mem_wr_o`=1, no register write, and `store_data_o` is register rd. Both use the add code. The two strobes are never 1 together.
- R5: When bits 31:30 are 00 and bits 24:22 are 100 (upper-immediate load), rd is written with bits 21:0 placed in bits 31:10 and zeros in bits 9:0. This value also appears on `sethi_val_o`, which is 0 for every other word.
- R6: When bits 31:30 are 00 and bits 24:22 are 010, the word is a branch with condition bits 28:25. The condition codes are 0001 (Z set), 0101 (C set), 0110 (N set), 0111 (V set) and 1000 (always), with `flags_i` ordered {N,Z,V,C}. `pc_sel_o` is 1 when the branch is taken and 0 otherwise. `pc_disp_o` is bits 21:0 sign-extended and shifted left by two.
- R7: Arithmetic op3 111000 (jump and link) sets `pc_sel_o`=2 (register target), writes rd, uses the add code and leaves `set_cc_o` at 0.
- R8: Register 0 reads as zero on every port, even after a write to it.
- R9: The all-ones word gives `halt_o`=1 and `pc_sel_o`=3 (hold), with no register write, no memory strobe and `illegal_o`=0.
- R10: Every other undefined encoding gives `illegal_o`=1. This covers an unlisted op3, a memory op3 other than load or store, bits 24:22 not 010 or 100 in class 00, and an unlisted branch condition. It also gives no register write, no memory strobe, `pc_sel_o`=0, `pc_disp_o`=0 and zero operands.
- R11: After reset every register reads as zero.
- R12: When `rf_we_o` is 1 at a rising clock edge and the write address is not 0, the register is written with the R5 value for the upper-immediate load and with `wr_data_i` otherwise. The new value is visible on the read ports from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register-file write |
| rst_n | input | 1 | Asynchronous active-low reset, clears all registers |
| instr_i | input | 32 | Instruction word to decode |
| flags_i | input | 4 | Condition flags {N,Z,V,C} |
| wr_data_i | input | 32 | Result from the datapath to be written to rd |
| src_a_o | output | 32 | Value of register rs1 |
| src_b_o | output | 32 | Value of register rs2 or the expanded immediate |
| store_data_o | output | 32 | Value of register rd for a store |
| alu_op_o | output | 3 | ALU operation code |
| set_cc_o | output | 1 | Update the condition flags |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wr_o | output | 1 | Memory write strobe |
| pc_sel_o | output | 2 | Next PC: 0 sequential, 1 relative, 2 register, 3 hold |
| pc_disp_o | output | 32 | Byte displacement for a relative transfer |
| rf_we_o | output | 1 | Register write enable |
| rf_waddr_o | output | 5 | Register write address |
| sethi_val_o | output | 32 | Upper-immediate value |
| halt_o | output | 1 | Halt word decoded |
| illegal_o | output | 1 | Undefined encoding decoded |

## Verification
The checks assume that `instr_i`, `flags_i` and `wr_data_i` hold fully defined 0/1 values from the first edge after reset. They also assume these inputs change only between edges, so the decoded write enable and address are stable when a register is written. The stimulus keeps within this by driving every input just after a rising edge, starting before reset is released. Words come from directed encodings and from random words with legal op3 values mixed in often enough to reach every class.

// File: rtl/idu_pkg.sv
package idu_pkg;
  localparam int ILEN = 32;

  typedef enum logic [1:0] {
    CLS_BRSETHI = 2'b00,
    CLS_CALL    = 2'b01,
    CLS_ALU     = 2'b10,
    CLS_MEM     = 2'b11
  } iclass_e;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_AND = 3'd1,
    ALU_OR  = 3'd2,
    ALU_ORN = 3'd3,
    ALU_SRL = 3'd4,
    ALU_SUB = 3'd5
  } alu_op_e;

  typedef enum logic [1:0] {
    PC_SEQ  = 2'd0,
    PC_REL  = 2'd1,
    PC_REG  = 2'd2,
    PC_HOLD = 2'd3
  } pc_sel_e;

  typedef enum logic [1:0] {
    IMM_SEXT  = 2'd0,
    IMM_ZEXT  = 2'd1,
    IMM_SHAMT = 2'd2
  } imm_kind_e;

  localparam logic [5:0] OP3_ADD  = 6'b010000;
  localparam logic [5:0] OP3_AND  = 6'b010001;
  localparam logic [5:0] OP3_OR   = 6'b010010;
  localparam logic [5:0] OP3_ORN  = 6'b010110;
  localparam logic [5:0] OP3_SUB  = 6'b010100;
  localparam logic [5:0] OP3_SRL  = 6'b100110;
  localparam logic [5:0] OP3_JMPL = 6'b111000;
  localparam logic [5:0] OP3_LD   = 6'b000000;
  localparam logic [5:0] OP3_ST   = 6'b000100;
  localparam logic [2:0] OP2_BR   = 3'b010;
  localparam logic [2:0] OP2_UPI  = 3'b100;
  localparam logic [4:0] LINK_REG = 5'd15;

  typedef struct packed {
    logic      rf_we;
    logic [4:0] waddr;
    logic [4:0] raddr_a;
    logic [4:0] raddr_b;
    logic [4:0] raddr_s;
    alu_op_e   alu_op;
    logic      set_cc;
    logic      use_imm;
    imm_kind_e imm_kind;
    logic      mem_rd;
    logic      mem_wr;
    logic      is_call;
    logic      is_branch;
    logic      is_jmpl;
    logic      is_upi;
    logic [3:0] cond;
    logic      halt;
    logic      illegal;
  } ctrl_t;

  function automatic logic [ILEN-1:0] imm_expand(input logic [12:0] f, input imm_kind_e k);
    case (k)
      IMM_ZEXT:  return {19'b0, f};
      IMM_SHAMT: return {27'b0, f[4:0]};
      default:   return {{19{f[12]}}, f};
    endcase
  endfunction

  function automatic logic [ILEN-1:0] upper_word(input logic [21:0] v);
    return {v, 10'b0};
  endfunction

  function automatic logic [ILEN-1:0] branch_offset(input logic [21:0] d);
    return {{8{d[21]}}, d, 2'b00};
  endfunction

  function automatic logic [ILEN-1:0] call_offset(input logic [29:0] d);
    return {d, 2'b00};
  endfunction

  function automatic logic cond_known(input logic [3:0] c);
    return (c == 4'b0001) || (c == 4'b0101) || (c == 4'b0110) ||
           (c == 4'b0111) || (c == 4'b1000);
  endfunction
endpackage

// File: rtl/idu_decoder.sv
module idu_decoder
  import idu_pkg::*;
(
  input  logic [ILEN-1:0] instr_i,
  output ctrl_t           ctrl_o
);
  iclass_e    cls;
  logic [4:0] f_rd, f_rs1, f_rs2;
  logic [5:0] f_op3;
  logic [2:0] f_op2;
  logic       f_imm;
  logic       legal;

  assign cls   = iclass_e'(instr_i[31:30]);
  assign f_rd  = instr_i[29:25];
  assign f_op3 = instr_i[24:19];
  assign f_rs1 = instr_i[18:14];
  assign f_imm = instr_i[13];
  assign f_rs2 = instr_i[4:0];
  assign f_op2 = instr_i[24:22];

  always_comb begin
    ctrl_o          = '0;
    ctrl_o.alu_op   = ALU_ADD;
    ctrl_o.imm_kind = IMM_SEXT;
    legal           = 1'b1;
    if (instr_i == '1) begin
      ctrl_o.halt = 1'b1;
    end else begin
      case (cls)
        CLS_CALL: begin
          ctrl_o.rf_we   = 1'b1;
          ctrl_o.waddr   = LINK_REG;
          ctrl_o.is_call = 1'b1;
        end
        CLS_ALU: begin
          case (f_op3)
            OP3_ADD:  begin ctrl_o.alu_op = ALU_ADD; ctrl_o.set_cc = 1'b1; end
            OP3_SUB:  begin ctrl_o.alu_op = ALU_SUB; ctrl_o.set_cc = 1'b1; end
            OP3_AND:  begin ctrl_o.alu_op = ALU_AND; ctrl_o.set_cc = 1'b1;
                            ctrl_o.imm_kind = IMM_ZEXT; end
            OP3_OR:   begin ctrl_o.alu_op = ALU_OR;  ctrl_o.set_cc = 1'b1;
                            ctrl_o.imm_kind = IMM_ZEXT; end
            OP3_ORN:  begin ctrl_o.alu_op = ALU_ORN; ctrl_o.set_cc = 1'b1;
                            ctrl_o.imm_kind = IMM_ZEXT; end
            OP3_SRL:  begin ctrl_o.alu_op = ALU_SRL; ctrl_o.imm_kind = IMM_SHAMT; end
            OP3_JMPL: begin ctrl_o.alu_op = ALU_ADD; ctrl_o.is_jmpl = 1'b1; end
            default:  legal = 1'b0;
          endcase
          if (legal) begin
            ctrl_o.rf_we   = 1'b1;
            ctrl_o.waddr   = f_rd;
            ctrl_o.raddr_a = f_rs1;
            ctrl_o.raddr_b = f_imm ? 5'd0 : f_rs2;
            ctrl_o.use_imm = f_imm;
          end
        end
        CLS_MEM: begin
          if (f_op3 == OP3_LD) begin
            ctrl_o.mem_rd = 1'b1;
            ctrl_o.rf_we  = 1'b1;
            ctrl_o.waddr  = f_rd;
          end else if (f_op3 == OP3_ST) begin
            ctrl_o.mem_wr  = 1'b1;
            ctrl_o.raddr_s = f_rd;
          end else begin
            legal = 1'b0;
          end
          if (legal) begin
            ctrl_o.raddr_a = f_rs1;
            ctrl_o.raddr_b = f_imm ? 5'd0 : f_rs2;
            ctrl_o.use_imm = f_imm;
          end
        end
        default: begin
          if (f_op2 == OP2_BR && cond_known(instr_i[28:25])) begin
            ctrl_o.is_branch = 1'b1;
            ctrl_o.cond      = instr_i[28:25];
          end else if (f_op2 == OP2_UPI) begin
            ctrl_o.is_upi = 1'b1;
            ctrl_o.rf_we  = 1'b1;
            ctrl_o.waddr  = f_rd;
          end else begin
            legal = 1'b0;
          end
        end
      endcase
      if (!legal) begin
        ctrl_o          = '0;
        ctrl_o.alu_op   = ALU_ADD;
        ctrl_o.imm_kind = IMM_SEXT;
        ctrl_o.illegal  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/idu_branch_eval.sv
module idu_branch_eval (
  input  logic [3:0] cond_i,
  input  logic [3:0] flags_i,
  output logic       taken_o
);
  logic f_n, f_z, f_v, f_c;
  assign {f_n, f_z, f_v, f_c} = flags_i;

  always_comb begin
    case (cond_i)
      4'b0001: taken_o = f_z;
      4'b0101: taken_o = f_c;
      4'b0110: taken_o = f_n;
      4'b0111: taken_o = f_v;
      4'b1000: taken_o = 1'b1;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/idu_regfile.sv
module idu_regfile #(
  parameter int NREG = 32,
  parameter int XLEN = 32,
  parameter int NRD  = 3,
  localparam int AW  = $clog2(NREG)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we_i,
  input  logic [AW-1:0]            waddr_i,
  input  logic [XLEN-1:0]          wdata_i,
  input  logic [NRD-1:0][AW-1:0]   raddr_i,
  output logic [NRD-1:0][XLEN-1:0] rdata_o
);
  logic [XLEN-1:0] regs [NREG];
  logic            wr_hit;

  assign wr_hit = we_i && (waddr_i != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NREG; k++) regs[k] <= '0;
    end else if (wr_hit) begin
      regs[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (raddr_i[p] == '0) ? '0 : regs[raddr_i[p]];
  end

  p_write_lands_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> regs[$past(waddr_i)] == $past(wdata_i));

  p_zero_stays_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && waddr_i == '0) |=> regs[0] == '0);
endmodule

// File: rtl/instr_decode_unit.sv
module instr_decode_unit
  import idu_pkg::*;
#(
  parameter int NREG = 32,
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [31:0]     instr_i,
  input  logic [3:0]      flags_i,
  input  logic [XLEN-1:0] wr_data_i,
  output logic [XLEN-1:0] src_a_o,
  output logic [XLEN-1:0] src_b_o,
  output logic [XLEN-1:0] store_data_o,
  output logic [2:0]      alu_op_o,
  output logic            set_cc_o,
  output logic            mem_rd_o,
  output logic            mem_wr_o,
  output logic [1:0]      pc_sel_o,
  output logic [XLEN-1:0] pc_disp_o,
  output logic            rf_we_o,
  output logic [4:0]      rf_waddr_o,
  output logic [XLEN-1:0] sethi_val_o,
  output logic            halt_o,
  output logic            illegal_o
);
  localparam int AW  = $clog2(NREG);
  localparam int NRD = 3;

  ctrl_t                     ctrl;
  logic                      br_taken;
  pc_sel_e                   pc_sel;
  logic [XLEN-1:0]           imm_val;
  logic [XLEN-1:0]           upi_val;
  logic [XLEN-1:0]           rf_wdata;
  logic [NRD-1:0][AW-1:0]    rf_raddr;
  logic [NRD-1:0][XLEN-1:0]  rf_rdata;

  idu_decoder u_dec (
    .instr_i (instr_i),
    .ctrl_o  (ctrl)
  );

  idu_branch_eval u_br (
    .cond_i  (ctrl.cond),
    .flags_i (flags_i),
    .taken_o (br_taken)
  );

  assign rf_raddr[0] = AW'(ctrl.raddr_a);
  assign rf_raddr[1] = AW'(ctrl.raddr_b);
  assign rf_raddr[2] = AW'(ctrl.raddr_s);

  assign upi_val  = upper_word(instr_i[21:0]);
  assign imm_val  = imm_expand(instr_i[12:0], ctrl.imm_kind);
  assign rf_wdata = ctrl.is_upi ? upi_val : wr_data_i;

  idu_regfile #(.NREG(NREG), .XLEN(XLEN), .NRD(NRD)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (ctrl.rf_we),
    .waddr_i (AW'(ctrl.waddr)),
    .wdata_i (rf_wdata),
    .raddr_i (rf_raddr),
    .rdata_o (rf_rdata)
  );

  always_comb begin
    if (ctrl.halt)                     pc_sel = PC_HOLD;
    else if (ctrl.is_call)             pc_sel = PC_REL;
    else if (ctrl.is_branch)           pc_sel = br_taken ? PC_REL : PC_SEQ;
    else if (ctrl.is_jmpl)             pc_sel = PC_REG;
    else                               pc_sel = PC_SEQ;
  end

  always_comb begin
    if (ctrl.is_call)        pc_disp_o = call_offset(instr_i[29:0]);
    else if (ctrl.is_branch) pc_disp_o = branch_offset(instr_i[21:0]);
    else                     pc_disp_o = '0;
  end

  assign src_a_o      = rf_rdata[0];
  assign src_b_o      = ctrl.use_imm ? imm_val : rf_rdata[1];
  assign store_data_o = rf_rdata[2];
  assign alu_op_o     = ctrl.alu_op;
  assign set_cc_o     = ctrl.set_cc;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign pc_sel_o     = pc_sel;
  assign rf_we_o      = ctrl.rf_we;
  assign rf_waddr_o   = ctrl.waddr;
  assign sethi_val_o  = ctrl.is_upi ? upi_val : '0;
  assign halt_o       = ctrl.halt;
  assign illegal_o    = ctrl.illegal;

  p_call_link_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_i[31:30] == 2'b01 && instr_i != '1) |-> (rf_we_o && rf_waddr_o == 5'd15 && pc_sel_o == 2'd1));

  p_strobes_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  p_upi_low_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sethi_val_o != '0) |-> (sethi_val_o[9:0] == 10'd0 && rf_we_o));

  p_jmpl_reg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_sel_o == 2'd2) |-> (rf_we_o && !set_cc_o && alu_op_o == 3'd0));

  p_halt_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halt_o |-> (pc_sel_o == 2'd3 && !rf_we_o && !mem_rd_o && !mem_wr_o && !illegal_o));

  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> (!rf_we_o && !mem_rd_o && !mem_wr_o && pc_sel_o == 2'd0 && !halt_o));

  p_one_event_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({halt_o, illegal_o, mem_rd_o, mem_wr_o}));
endmodule

// File: tb/sim_instr_decode_unit.sv
module sim_instr_decode_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] instr = 32'h0;
  logic [3:0]  flags = 4'h0;
  logic [31:0] wdata = 32'h0;
  logic [31:0] src_a, src_b, st_data, pc_disp, upi;
  logic [2:0]  alu_op;
  logic        set_cc, mem_rd, mem_wr, we, halt, illegal;
  logic [1:0]  pc_sel;
  logic [4:0]  waddr;

  int checks = 0;
  int fails  = 0;
  logic [31:0] m [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  instr_decode_unit u0 (
    .clk(clk), .rst_n(rst_n), .instr_i(instr), .flags_i(flags), .wr_data_i(wdata),
    .src_a_o(src_a), .src_b_o(src_b), .store_data_o(st_data), .alu_op_o(alu_op),
    .set_cc_o(set_cc), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr), .pc_sel_o(pc_sel),
    .pc_disp_o(pc_disp), .rf_we_o(we), .rf_waddr_o(waddr), .sethi_val_o(upi),
    .halt_o(halt), .illegal_o(illegal)
  );

  function automatic logic [31:0] rreg(input logic [4:0] a);
    return (a == 0) ? 32'h0 : m[a];
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic [31:0] ins, input logic [3:0] fl, input logic [31:0] wd);
    logic [31:0] e_a, e_b, e_s, e_disp, e_upi;
    logic [2:0]  e_op;
    logic [1:0]  e_pc;
    logic [4:0]  e_wa;
    logic        e_cc, e_mr, e_mw, e_we, e_halt, e_ill, known, tk;
    int          kind;
    logic [5:0]  op3;
    instr = ins; flags = fl; wdata = wd;
    @(negedge clk);
    e_a = 0; e_b = 0; e_s = 0; e_disp = 0; e_upi = 0; e_op = 0; e_pc = 0; e_wa = 0;
    e_cc = 0; e_mr = 0; e_mw = 0; e_we = 0; e_halt = 0; e_ill = 0; kind = 0;
    op3 = ins[24:19];
    if (ins == 32'hFFFF_FFFF) begin
      e_halt = 1; e_pc = 3;
    end else if (ins[31:30] == 2'b01) begin
      e_we = 1; e_wa = 15; e_pc = 1; e_disp = ins << 2;
    end else if (ins[31:30] == 2'b10 || ins[31:30] == 2'b11) begin
      known = 1;
      if (ins[31:30] == 2'b10) begin
        e_we = 1; e_wa = ins[29:25]; e_cc = 1;
        if (op3 == 6'b010000)      e_op = 0;
        else if (op3 == 6'b010100) e_op = 5;
        else if (op3 == 6'b010001) begin e_op = 1; kind = 1; end
        else if (op3 == 6'b010010) begin e_op = 2; kind = 1; end
        else if (op3 == 6'b010110) begin e_op = 3; kind = 1; end
        else if (op3 == 6'b100110) begin e_op = 4; kind = 2; e_cc = 0; end
        else if (op3 == 6'b111000) begin e_pc = 2; e_cc = 0; end
        else known = 0;
      end else begin
        if (op3 == 6'b000000) begin e_mr = 1; e_we = 1; e_wa = ins[29:25]; end
        else if (op3 == 6'b000100) begin e_mw = 1; e_s = rreg(ins[29:25]); end
        else known = 0;
      end
      if (known) begin
        e_a = rreg(ins[18:14]);
        if (!ins[13]) e_b = rreg(ins[4:0]);
        else if (kind == 1) e_b = 32'(ins[12:0]);
        else if (kind == 2) e_b = 32'(ins[4:0]);
        else e_b = 32'($signed(ins[12:0]));
      end else begin
        e_a = 0; e_b = 0; e_s = 0; e_op = 0; e_pc = 0; e_wa = 0;
        e_cc = 0; e_mr = 0; e_mw = 0; e_we = 0; e_ill = 1;
      end
    end else begin
      if (ins[24:22] == 3'b010) begin
        known = 1;
        case (ins[28:25])
          4'b0001: tk = fl[2];
          4'b0101: tk = fl[0];
          4'b0110: tk = fl[3];
          4'b0111: tk = fl[1];
          4'b1000: tk = 1;
          default: begin tk = 0; known = 0; end
        endcase
        if (known) begin
          e_pc = tk ? 2'd1 : 2'd0;
          e_disp = 32'($signed(ins[21:0])) * 4;
        end else e_ill = 1;
      end else if (ins[24:22] == 3'b100) begin
        e_we = 1; e_wa = ins[29:25]; e_upi = ins[21:0] * 1024;
      end else e_ill = 1;
    end
    chk(tag, "src_a", src_a, e_a);
    chk(tag, "src_b", src_b, e_b);
    chk(tag, "store_data", st_data, e_s);
    chk(tag, "alu_op", 32'(alu_op), 32'(e_op));
    chk(tag, "set_cc", 32'(set_cc), 32'(e_cc));
    chk(tag, "mem_rd", 32'(mem_rd), 32'(e_mr));
    chk(tag, "mem_wr", 32'(mem_wr), 32'(e_mw));
    chk(tag, "pc_sel", 32'(pc_sel), 32'(e_pc));
    chk(tag, "pc_disp", pc_disp, e_disp);
    chk(tag, "rf_we", 32'(we), 32'(e_we));
    chk(tag, "rf_waddr", 32'(waddr), 32'(e_wa));
    chk(tag, "sethi_val", upi, e_upi);
    chk(tag, "halt", 32'(halt), 32'(e_halt));
    chk(tag, "illegal", 32'(illegal), 32'(e_ill));
    if (e_we && e_wa != 0) m[e_wa] = (e_upi != 0 || (ins[31:30] == 2'b00 && ins[24:22] == 3'b100)) ? e_upi : wd;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [31:0] fa(input logic [5:0] op3, input logic [4:0] rd, input logic [4:0] rs1,
                                     input logic i, input logic [12:0] low);
    return {2'b10, rd, op3, rs1, i, low};
  endfunction

  function automatic logic [31:0] fm(input logic [5:0] op3, input logic [4:0] rd, input logic [4:0] rs1,
                                     input logic i, input logic [12:0] low);
    return {2'b11, rd, op3, rs1, i, low};
  endfunction

  function automatic logic [31:0] fb(input logic [3:0] cond, input logic [21:0] d);
    return {2'b00, 1'b0, cond, 3'b010, d};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [5:0] legal_op3 [9];
    for (int k = 0; k < 32; k++) m[k] = 32'h0;
    legal_op3 = '{6'b010000, 6'b010001, 6'b010010, 6'b010110, 6'b010100,
                  6'b100110, 6'b111000, 6'b000000, 6'b000100};
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;

    // R11: registers read zero after reset
    step("R11", fa(6'b010000, 5'd3, 5'd1, 1'b0, 13'd2), 4'h0, 32'h0);
    step("R11", fm(6'b000100, 5'd31, 5'd30, 1'b0, 13'd29), 4'h0, 32'h0);
    // R4 / R12: loads place wr_data into registers
    step("R4",  fm(6'b000000, 5'd1, 5'd0, 1'b1, 13'd20), 4'h0, 32'h1234_5678);
    step("R12", fm(6'b000000, 5'd2, 5'd0, 1'b0, 13'd0), 4'h0, 32'hFFFF_0001);
    step("R12", fa(6'b010000, 5'd3, 5'd1, 1'b0, 13'd2), 4'h0, 32'h0000_00A5);
    // R2 / R3: operations and immediate expansion
    step("R3",  fa(6'b010000, 5'd4, 5'd1, 1'b1, 13'h1FFF), 4'h0, 32'h11);
    step("R3",  fa(6'b010001, 5'd4, 5'd2, 1'b1, 13'h1FFF), 4'h0, 32'h22);
    step("R3",  fa(6'b100110, 5'd4, 5'd2, 1'b1, 13'h1FE3), 4'h0, 32'h33);
    step("R2",  fa(6'b010100, 5'd5, 5'd1, 1'b0, 13'd3), 4'h0, 32'h44);
    step("R2",  fa(6'b010010, 5'd6, 5'd3, 1'b1, 13'h1000), 4'h0, 32'h55);
    step("R2",  fa(6'b010110, 5'd7, 5'd2, 1'b0, 13'd4), 4'h0, 32'h66);
    step("R2",  fa(6'b100110, 5'd8, 5'd1, 1'b0, 13'd5), 4'h0, 32'h77);
    // R4: store reads rd as data, address operands from rs1/rs2
    step("R4",  fm(6'b000100, 5'd1, 5'd2, 1'b0, 13'd3), 4'h0, 32'hDEAD_BEEF);
    step("R4",  fm(6'b000100, 5'd3, 5'd1, 1'b1, 13'h1FF0), 4'h0, 32'hDEAD_BEEF);
    // R5: upper-immediate load, then read back
    step("R5",  {2'b00, 5'd9, 3'b100, 22'h2AF366}, 4'h0, 32'h0);
    step("R5",  fa(6'b010000, 5'd10, 5'd9, 1'b0, 13'd0), 4'h0, 32'h0);
    // R1: call writes link register 15
    step("R1",  {2'b01, 30'd10}, 4'h0, 32'h0000_0040);
    step("R1",  {2'b01, 30'h3FFF_FFFE}, 4'h0, 32'h0000_0080);
    step("R1",  fa(6'b010000, 5'd11, 5'd15, 1'b0, 13'd15), 4'h0, 32'h0);
    // R6: branch conditions against flags {N,Z,V,C}
    step("R6",  fb(4'b0001, 22'd5), 4'b0100, 32'h0);
    step("R6",  fb(4'b0001, 22'd5), 4'b1011, 32'h0);
    step("R6",  fb(4'b0101, 22'h3FFFFC), 4'b0001, 32'h0);
    step("R6",  fb(4'b0101, 22'h3FFFFC), 4'b1110, 32'h0);
    step("R6",  fb(4'b0110, 22'd7), 4'b1000, 32'h0);
    step("R6",  fb(4'b0111, 22'd7), 4'b0010, 32'h0);
    step("R6",  fb(4'b0111, 22'd7), 4'b1101, 32'h0);
    step("R6",  fb(4'b1000, 22'd1), 4'b0000, 32'h0);
    // R7 / R8: jump and link to r0, then r0 still zero
    step("R7",  fa(6'b111000, 5'd0, 5'd15, 1'b1, 13'd4), 4'h0, 32'h1234_0000);
    step("R8",  fm(6'b000000, 5'd0, 5'd1, 1'b1, 13'd0), 4'h0, 32'hFFFF_FFFF);
    step("R8",  fm(6'b000100, 5'd0, 5'd0, 1'b0, 13'd0), 4'h0, 32'h0);
    step("R8",  {2'b00, 5'd0, 3'b100, 22'h3FFFFF}, 4'h0, 32'h0);
    step("R8",  fa(6'b010010, 5'd12, 5'd0, 1'b0, 13'd0), 4'h0, 32'h0);
    // R9: halt
    step("R9",  32'hFFFF_FFFF, 4'hF, 32'h9999_9999);
    step("R9",  fa(6'b010000, 5'd13, 5'd1, 1'b0, 13'd0), 4'h0, 32'h0);
    // R10: illegal encodings leave registers untouched
    step("R10", fa(6'b000111, 5'd1, 5'd2, 1'b0, 13'd3), 4'h0, 32'hBAD0_0001);
    step("R10", fm(6'b000001, 5'd2, 5'd1, 1'b1, 13'd8), 4'h0, 32'hBAD0_0002);
    step("R10", {2'b00, 5'd3, 3'b000, 22'h12345}, 4'h0, 32'hBAD0_0003);
    step("R10", fb(4'b0011, 22'd9), 4'hF, 32'hBAD0_0004);
    step("R10", fm(6'b111111, 5'd1, 5'd2, 1'b0, 13'd3), 4'h0, 32'hBAD0_0005);
    step("R10", fa(6'b010000, 5'd14, 5'd1, 1'b0, 13'd2), 4'h0, 32'h0);
    step("R10", fa(6'b010000, 5'd14, 5'd3, 1'b0, 13'd0), 4'h0, 32'h0);

    // R12 and all others: mixed random words
    for (int n = 0; n < 600; n++) begin
      logic [31:0] w;
      w = $urandom;
      if (n % 3 != 0) w[24:19] = legal_op3[$urandom % 9];
      if (n % 5 == 0) w[24:22] = ($urandom % 2) ? 3'b010 : 3'b100;
      step("R12", w, 4'($urandom), $urandom);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule